// File: doc/BRIEF.md
# Time-Setting Strobe Controller

This controller sits in front of a time-of-day counter and decides, cycle by cycle, which of three advance strobes the counter receives: one that steps the hours, one that steps the minutes and one that lets the seconds chain follow the slow timebase clock. In normal running the seconds strobe is held high, so the counter advances on every clock edge. When the set-mode input is raised, the running strobe is withdrawn and the hour and minute buttons take over. Each press of a button produces exactly one single-cycle step, however long the button stays held.

The button and mode levels are assumed to be already synchronised to the clock and free of bounce. Internally the block has three states: a running state, a state that holds after an hour step and a state that holds after a minute step. The strobes are decoded from the current state and the present inputs, so a press is answered in the same cycle in which it is first seen. The asynchronous active-low reset is released through a short synchroniser, and all strobes stay low until that release has taken effect.

Top module: `settime_ctrl`

## Requirements
- R1: While `rst_n` is low, all three strobes are low, even when the inputs would otherwise raise one. After `rst_n` rises, the strobes stay low for RST_STAGES-1 clock edges and then follow the state machine. The machine starts in the running state.
- R2: In the running state with `set_mode` low, `step_sec` is high and `step_hr` and `step_min` are low, whatever the button levels are.
- R3: In the running state with `set_mode` high, `btn_hr` high and `btn_min` low, `step_hr` is high for that cycle only and the machine moves to the hour-hold state.
- R4: In the running state with `set_mode` high, `btn_min` high and `btn_hr` low, `step_min` is high for that cycle only and the machine moves to the minute-hold state.
- R5: A hold state keeps itself and drives all strobes low for as long as the input pattern that entered it is unchanged, so a held button gives exactly one step.
- R6: From either hold state, any other input pattern returns the machine to the running state, with all strobes low in that transition cycle.
- R7: In the running state with `set_mode` high and either no button or both buttons pressed, all strobes are low and the machine stays in the running state.
- R8: At most one of the three strobes is high in any cycle, and neither `step_hr` nor `step_min` is ever high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_mode | input | 1 | High while the time is being set |
| btn_hr | input | 1 | Hour button level, synchronised |
| btn_min | input | 1 | Minute button level, synchronised |
| step_hr | output | 1 | Single-cycle hour increment |
| step_min | output | 1 | Single-cycle minute increment |
| step_sec | output | 1 | Seconds-count enable while running |

## Verification
The state is held only in the machine's register, so a wrong state becomes visible at the ports in the first cycle in which an input pattern tells the states apart. A machine that failed to leave a hold state would suppress `step_sec` as soon as `set_mode` fell. A machine that failed to enter a hold state would repeat a step on the next cycle of a held press. The stimulus therefore holds every press for several cycles, releases it both to idle and to the other button, and follows each hold with a cycle of idle input.

// File: rtl/settime_pkg.sv
package settime_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLDH = 2'd1,
    ST_HOLDM = 2'd2
  } settime_state_e;

  typedef struct packed {
    logic hr;
    logic mn;
    logic sec;
  } settime_strobe_t;

  localparam settime_strobe_t STROBE_NONE = '{hr: 1'b0, mn: 1'b0, sec: 1'b0};

endpackage

// File: rtl/settime_rstsync.sv
module settime_rstsync #(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  localparam int LAST = RST_STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (RST_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_ok = chain_q[LAST];

  // R1
  rst_low_clears_chk: assert property (@(posedge clk) !rst_n |-> !rst_ok)
    else $error("rst_ok high while rst_n low");
endmodule

// File: rtl/settime_decode.sv
module settime_decode
  import settime_pkg::*;
(
  input  settime_state_e  cur,
  input  logic            set_mode,
  input  logic            btn_hr,
  input  logic            btn_min,
  output settime_state_e  nxt,
  output settime_strobe_t strobes
);
  logic only_hr;
  logic only_min;

  assign only_hr  = set_mode &  btn_hr & ~btn_min;
  assign only_min = set_mode & ~btn_hr &  btn_min;

  always_comb begin
    nxt     = cur;
    strobes = STROBE_NONE;
    unique case (cur)
      ST_RUN: begin
        if (!set_mode) begin
          strobes.sec = 1'b1;
        end else if (only_hr) begin
          strobes.hr = 1'b1;
          nxt        = ST_HOLDH;
        end else if (only_min) begin
          strobes.mn = 1'b1;
          nxt        = ST_HOLDM;
        end
      end
      ST_HOLDH: begin
        if (!only_hr) nxt = ST_RUN;
      end
      ST_HOLDM: begin
        if (!only_min) nxt = ST_RUN;
      end
      default: begin
        nxt = ST_RUN;
      end
    endcase
  end
endmodule

// File: rtl/settime_state_reg.sv
module settime_state_reg
  import settime_pkg::*;
(
  input  logic           clk,
  input  logic           rst_ok,
  input  settime_state_e nxt,
  output settime_state_e cur
);
  logic upd_en;

  assign upd_en = (nxt != cur);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     cur <= ST_RUN;
    else if (upd_en) cur <= nxt;
  end
endmodule

// File: rtl/settime_ctrl.sv
module settime_ctrl
  import settime_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_mode,
  input  logic btn_hr,
  input  logic btn_min,
  output logic step_hr,
  output logic step_min,
  output logic step_sec
);
  logic            rst_ok;
  settime_state_e  cur;
  settime_state_e  nxt;
  settime_strobe_t raw;

  settime_rstsync #(.RST_STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ok(rst_ok)
  );

  settime_decode u_dec (
    .cur     (cur),
    .set_mode(set_mode),
    .btn_hr  (btn_hr),
    .btn_min (btn_min),
    .nxt     (nxt),
    .strobes (raw)
  );

  settime_state_reg u_reg (
    .clk   (clk),
    .rst_ok(rst_ok),
    .nxt   (nxt),
    .cur   (cur)
  );

  assign step_hr  = raw.hr  & rst_ok;
  assign step_min = raw.mn  & rst_ok;
  assign step_sec = raw.sec & rst_ok;

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({step_hr, step_min, step_sec}))
    else $error("more than one strobe high");

  // R8
  hr_single_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    step_hr |=> !step_hr)
    else $error("hour strobe two cycles in a row");

  // R8
  min_single_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    step_min |=> !step_min)
    else $error("minute strobe two cycles in a row");

  // R3
  hr_enters_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    step_hr |=> (cur == ST_HOLDH))
    else $error("hour step did not enter hold");

  // R4
  min_enters_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    step_min |=> (cur == ST_HOLDM))
    else $error("minute step did not enter hold");

  // R2
  sec_only_running_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    step_sec |-> (!set_mode && cur == ST_RUN))
    else $error("seconds strobe outside running with mode low");

  // R6
  hold_exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (cur != ST_RUN) |-> !(step_hr || step_min || step_sec))
    else $error("strobe raised from a hold state");
endmodule

// File: tb/sim_settime_ctrl.sv
module sim_settime_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_mode = 1'b0;
  logic btn_hr = 1'b0;
  logic btn_min = 1'b0;
  logic step_hr, step_min, step_sec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  settime_ctrl #(.RST_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .set_mode(set_mode),
    .btn_hr(btn_hr), .btn_min(btn_min),
    .step_hr(step_hr), .step_min(step_min), .step_sec(step_sec)
  );

  // Vector: [8:6] requirement number, [5:3] {set_mode,btn_hr,btn_min},
  // [2:0] expected {step_hr,step_min,step_sec}. Applied one per cycle.
  localparam int NV = 20;
  localparam logic [8:0] VEC [NV] = '{
    {3'd2, 3'b000, 3'b001},  // R2 idle running
    {3'd2, 3'b011, 3'b001},  // R2 buttons ignored, mode low
    {3'd7, 3'b100, 3'b000},  // R7 mode high, no button
    {3'd4, 3'b101, 3'b010},  // R4 minute step
    {3'd5, 3'b101, 3'b000},  // R5 held
    {3'd5, 3'b101, 3'b000},  // R5 held
    {3'd6, 3'b100, 3'b000},  // R6 release to running
    {3'd4, 3'b101, 3'b010},  // R4 second press
    {3'd6, 3'b110, 3'b000},  // R6 switch to other button
    {3'd3, 3'b110, 3'b100},  // R3 hour step
    {3'd5, 3'b110, 3'b000},  // R5 held
    {3'd6, 3'b000, 3'b000},  // R6 mode drop, quiet exit
    {3'd2, 3'b000, 3'b001},  // R2 running again
    {3'd2, 3'b010, 3'b001},  // R2 hour button, mode low
    {3'd7, 3'b111, 3'b000},  // R7 both buttons
    {3'd3, 3'b110, 3'b100},  // R3 hour step
    {3'd6, 3'b111, 3'b000},  // R6 both pressed in hold
    {3'd4, 3'b101, 3'b010},  // R4 minute step
    {3'd6, 3'b001, 3'b000},  // R6 mode drop in minute hold
    {3'd2, 3'b000, 3'b001}   // R2
  };

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {step_hr, step_min, step_sec};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] v);
    {set_mode, btn_hr, btn_min} = v;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    // R1: strobes low in reset even with inputs that would raise step_sec
    drive(3'b000);
    repeat (3) @(negedge clk);
    #5 chk("R1 in reset", 3'b000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #5 chk("R1 sync delay", 3'b000);
    @(negedge clk); #5 chk("R1 released, running", 3'b001);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][5:3]);
      #5 chk($sformatf("R%0d vec %0d", VEC[i][8:6], i), VEC[i][2:0]);
    end

    // R5: long hold of the hour button gives one step only
    @(negedge clk); drive(3'b000);
    @(negedge clk); drive(3'b110);
    #5 chk("R3 step before long hold", 3'b100);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      #5 chk("R5 long hold quiet", 3'b000);
    end

    // R1: asynchronous reset from the hour-hold state
    @(posedge clk); #3 rst_n = 1'b0;
    #2 drive(3'b000);
    #1 chk("R1 async assert", 3'b000);
    @(negedge clk); rst_n = 1'b1;
    drive(3'b101);
    #5 chk("R1 gated after release", 3'b000);
    @(negedge clk); #5 chk("R1 still gated", 3'b000);
    // state is running after reset: 101 yields a minute step, not silence
    @(negedge clk); #5 chk("R1 reset state is running", 3'b010);
    @(negedge clk); #5 chk("R5 hold after reset step", 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule